// File: doc/BRIEF.md
# Comparator output sample filter

This block turns the raw, possibly noisy output bit of an analog comparator into a clean digital level, `cout_o`. A single 8-bit control register sets how it does this. A 3-bit count selects how many consecutive samples must agree before the output moves. A sample-select bit chooses where the sample timing comes from. A window-select bit lets an external gate freeze the output. A hysteresis-level bit is only stored and shown on a pin.

The raw comparator bit and the external sample input each pass through a two-flop synchronizer first. With a count of zero the filter is bypassed. In that case the output follows the synchronized comparator bit, or is forced low when external sampling is selected. With a count from 1 to 7, the output takes a new level only after that many back-to-back samples show it. Samples come from a periodic strobe input, or from rising edges of the external sample input when sample-select is set.

Top module: `cmp_sample_filter`

## Requirements
- R1: After reset the register reads 0x00, and `cout_o` and `hyst_o` are 0.
- R2: Register layout: bits [2:0] hold the filter count, bit 4 holds the hysteresis level, bit 6 holds window-select and bit 7 holds sample-select. Bits 3 and 5 ignore writes and always read 0. `rdata_o` shows the register at all times.
- R3: A write with both bit 7 and bit 6 set stores sample-select as 1 and window-select as 0. The two bits never read back as 1 together.
- R4: With a count of 0 and both select bits clear, `cout_o` equals `raw_i` delayed by exactly three clock cycles: two synchronizer stages and the output register.
- R5: With a count of 0 and sample-select set, `cout_o` is 0 whatever `raw_i` does.
- R6: With a count N from 1 to 7 and window-select clear, `cout_o` changes only after N consecutive samples show the new level. A sample equal to the current output restarts the run.
- R7: With a count of 1, every sample is passed straight to `cout_o`.
- R8: With sample-select clear, a sample is taken in each cycle where `strobe_i` is high. With sample-select set, a sample is taken once per rising edge of the synchronized `ext_smp_i`, and `strobe_i` has no effect.
- R9: With window-select set, `cout_o` holds its value while `window_i` is low, and no sampling happens. While `window_i` is high, `cout_o` follows the synchronized `raw_i` with the R4 latency.
- R10: Every register write clears the consecutive-agreement counter. Counting restarts from the next sample.
- R11: `hyst_o` always equals the stored hysteresis bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| raw_i | input | 1 | Raw comparator output (asynchronous) |
| strobe_i | input | 1 | Periodic internal sample strobe |
| ext_smp_i | input | 1 | External sample input (asynchronous) |
| window_i | input | 1 | Window gate, high = open |
| cout_o | output | 1 | Filtered comparator output |
| hyst_o | output | 1 | Stored hysteresis level |

## Verification
The bench sweeps every write value through the register. This catches a write that sets both select bits and keeps both, and reserved bits that leak written data. It runs every filter count from 1 to 7 and breaks an agreeing run one sample short. A design that does not restart on a disagreeing sample, or that is off by one in its compare, moves the output early or late. A rewrite in the middle of a run shows whether the counter is cleared. Strobes sent in external-sample mode and raw changes under a closed window must leave the output still. The bypass path is checked cycle by cycle, so an added or missing register stage is caught.

// File: rtl/cmp_filt_pkg.sv
package cmp_filt_pkg;
  localparam int REG_W     = 8;
  localparam int CNT_W     = 3;
  localparam int SYNC_N    = 2;
  localparam int POS_SE    = 7;
  localparam int POS_WE    = 6;
  localparam int POS_HYST  = 4;

  typedef struct packed {
    logic             samp_en;
    logic             win_en;
    logic             hyst;
    logic [CNT_W-1:0] filt_cnt;
  } cfg_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      cfg_q.samp_en  <= wdata_i[POS_SE];
      // sample-select wins when both are requested
      cfg_q.win_en   <= wdata_i[POS_WE] & ~wdata_i[POS_SE];
      cfg_q.hyst     <= wdata_i[POS_HYST];
      cfg_q.filt_cnt <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[POS_SE]      = cfg_q.samp_en;
    rdata_o[POS_WE]      = cfg_q.win_en;
    rdata_o[POS_HYST]    = cfg_q.hyst;
    rdata_o[CNT_W-1:0]   = cfg_q.filt_cnt;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cmp_filt_core.sv
module cmp_filt_core
  import cmp_filt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic clr_i,
  input  logic raw_i,
  input  logic smp_i,
  input  logic window_i,
  output logic cout_o
);
  logic [CNT_W-1:0] agree_q, agree_d;
  logic             cout_q, cout_d;
  logic             bypass, reached;

  assign bypass  = (cfg_i.filt_cnt == '0);
  assign reached = ({1'b0, agree_q} + 1'b1) >= {1'b0, cfg_i.filt_cnt};

  always_comb begin
    agree_d = agree_q;
    cout_d  = cout_q;
    if (cfg_i.samp_en && bypass) begin
      cout_d  = 1'b0;
      agree_d = '0;
    end else if (cfg_i.win_en) begin
      if (window_i) cout_d = raw_i;
    end else if (bypass) begin
      cout_d  = raw_i;
      agree_d = '0;
    end else if (smp_i) begin
      if (raw_i == cout_q) begin
        agree_d = '0;
      end else if (reached) begin
        cout_d  = raw_i;
        agree_d = '0;
      end else begin
        agree_d = agree_q + 1'b1;
      end
    end
    if (clr_i) agree_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agree_q <= '0;
      cout_q  <= 1'b0;
    end else begin
      agree_q <= agree_d;
      cout_q  <= cout_d;
    end
  end

  assign cout_o = cout_q;
endmodule

// File: rtl/cmp_sample_filter.sv
module cmp_sample_filter
  import cmp_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             raw_i,
  input  logic             strobe_i,
  input  logic             ext_smp_i,
  input  logic             window_i,
  output logic             cout_o,
  output logic             hyst_o
);
  cfg_t cfg;
  logic raw_s, ext_s, ext_d, smp;

  cmp_ctrl_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .cfg_o  (cfg)
  );

  cmp_sync #(.STAGES(SYNC_N)) u_sync_raw (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_i), .q_o(raw_s)
  );

  cmp_sync #(.STAGES(SYNC_N)) u_sync_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_smp_i), .q_o(ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d <= 1'b0;
    else         ext_d <= ext_s;
  end

  assign smp = cfg.samp_en ? (ext_s & ~ext_d) : strobe_i;

  cmp_filt_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg),
    .clr_i   (wr_en_i),
    .raw_i   (raw_s),
    .smp_i   (smp),
    .window_i(window_i),
    .cout_o  (cout_o)
  );

  assign hyst_o = cfg.hyst;
endmodule

// File: rtl/cmp_sample_filter_chk.sv
module cmp_sample_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rdata_o,
  input logic       strobe_i,
  input logic       window_i,
  input logic       cout_o,
  input logic       hyst_o
);
  assert_sel_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdata_o[7] && rdata_o[6]));

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[3] == 1'b0) && (rdata_o[5] == 1'b0));

  assert_force_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rdata_o[2:0] == 3'd0 && rdata_o[7]) |-> !cout_o);

  assert_win_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rdata_o[6] && !window_i) |-> $stable(cout_o));

  assert_no_strobe_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rdata_o[2:0] != 3'd0 && !rdata_o[7] && !rdata_o[6] && !strobe_i)
    |-> $stable(cout_o));

  assert_hyst_pin_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(hyst_o) |-> $changed(rdata_o[4]));
endmodule

bind cmp_sample_filter cmp_sample_filter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rdata_o (rdata_o),
  .strobe_i(strobe_i),
  .window_i(window_i),
  .cout_o  (cout_o),
  .hyst_o  (hyst_o)
);

// File: tb/cmp_sample_filter_test.sv
`timescale 1ns/1ps
module cmp_sample_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       raw = 1'b0, strobe = 1'b0, ext = 1'b0, window = 1'b0;
  logic       cout, hyst;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cmp_sample_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .raw_i(raw), .strobe_i(strobe), .ext_smp_i(ext),
    .window_i(window), .cout_o(cout), .hyst_o(hyst)
  );

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext = 1'b1; cyc(4);
    ext = 1'b0; cyc(4);
  endtask

  task automatic set_raw(logic v);
    @(negedge clk); raw = v; cyc(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    // R1
    chk("R1 rdata", rdata, 0);
    chk("R1 cout", cout, 0);
    chk("R1 hyst", hyst, 0);

    // R2 R3 R11 full write sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w, e;
      w = v[7:0];
      e = {w[7], w[6] & ~w[7], 1'b0, w[4], 1'b0, w[2:0]};
      wr(w);
      chk((w[7] && w[6]) ? "R3 both set" : "R2 readback", rdata, e);
      chk("R11 hyst pin", hyst, w[4]);
    end

    // R4 bypass latency
    wr(8'h00); set_raw(0); cyc(2);
    chk("R4 idle", cout, 0);
    @(negedge clk); raw = 1'b1;
    cyc(2); chk("R4 not before 3", cout, 0);
    cyc(1); chk("R4 at 3", cout, 1);
    @(negedge clk); raw = 1'b0;
    cyc(2); chk("R4 fall not before 3", cout, 1);
    cyc(1); chk("R4 fall at 3", cout, 0);

    // R5 forced low
    set_raw(1); chk("R5 pre", cout, 1);
    wr(8'h80); cyc(2);
    chk("R5 forced low", cout, 0);
    pulse(); ext_pulse(); chk("R5 stays low", cout, 0);

    // R6 R7 each count
    for (int n = 1; n <= 7; n++) begin
      wr(8'h00); set_raw(0); cyc(1);
      wr(n[7:0]); set_raw(1);
      for (int k = 1; k < n; k++) begin
        pulse();
        chk("R6 early", cout, 0);
      end
      if (n > 1) begin
        set_raw(0); pulse();
        set_raw(1);
        for (int k = 1; k < n; k++) pulse();
        chk("R6 run broken restarts", cout, 0);
      end
      cyc(3); chk("R8 no strobe no change", cout, 0);
      pulse();
      chk(n == 1 ? "R7 single sample" : "R6 after N", cout, 1);
      set_raw(0);
      for (int k = 1; k < n; k++) pulse();
      chk("R6 fall early", cout, 1);
      pulse();
      chk("R6 fall after N", cout, 0);
    end

    // R10 write clears counter
    wr(8'h00); set_raw(0); cyc(1);
    wr(8'h03); set_raw(1);
    pulse(); pulse();
    wr(8'h03);
    pulse(); pulse();
    chk("R10 cleared by write", cout, 0);
    pulse();
    chk("R10 count after write", cout, 1);

    // R8 external sample mode
    wr(8'h00); set_raw(0); cyc(1);
    wr(8'h82); set_raw(1);
    for (int k = 0; k < 4; k++) pulse();
    chk("R8 strobe ignored", cout, 0);
    ext_pulse(); chk("R8 one edge", cout, 0);
    ext_pulse(); chk("R8 two edges", cout, 1);

    // R9 window
    wr(8'h00); set_raw(0); cyc(1);
    @(negedge clk); window = 1'b1;
    wr(8'h43);
    @(negedge clk); raw = 1'b1;
    cyc(2); chk("R9 open not before 3", cout, 0);
    cyc(1); chk("R9 open follows", cout, 1);
    @(negedge clk); window = 1'b0; raw = 1'b0;
    cyc(5); pulse(); pulse(); pulse(); pulse();
    chk("R9 closed holds", cout, 1);
    @(negedge clk); window = 1'b1;
    cyc(1); chk("R9 reopen follows", cout, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule